// File: doc/BRIEF.md
# Bus System Arbiter with Fixed-Priority and Round-Robin Modes

This block is the arbiter that the system-controller board of a shared backplane bus runs. It watches a set of bus request levels (four by default) and the bus busy line. While the bus is free it offers the bus to exactly one level by raising that level's grant-out line. It takes the grant away as soon as the new owner signals busy, or when the request is withdrawn before busy appears.

Two policies are available. Fixed priority always serves the highest requesting level. It also raises bus clear to ask the current owner to let go when a level above the owner's starts requesting. Round robin serves levels in a descending scan that wraps around, one grant per level per scan, and never raises bus clear. Round robin is the reset mode. The arbiter works only while the board is the system controller. When that enable is low, every output stays quiet.

Top module: `vme_sys_arbiter`

## Requirements
- R1: At most one bit of `bus_grant` is high in any cycle.
- R2: With `fixed_sel` = 1, a grant goes to the highest set bit of `bus_req`. Bit 3 ranks highest and bit 0 lowest.
- R3: With `fixed_sel` = 1, while an owner holds `bus_busy`, a request on a level strictly above the owner's raises `bus_clr` one cycle later. A request on a lower level does not. `bus_clr` stays high while `bus_busy` stays high, even if the request is withdrawn, and drops one cycle after `bus_busy` is seen low.
- R4: With `fixed_sel` = 0, the search for the next grant starts one level below the last level granted in this mode and runs downward. It wraps from level 0 to level 3, so each level receives at most one grant per scan.
- R5: With `fixed_sel` = 0, `bus_clr` is never raised.
- R6: A new grant is issued only when `bus_busy` is low. It appears one cycle after a request is seen with the bus idle. No grant appears while `bus_busy` stays high.
- R7: A grant is removed one cycle after `bus_busy` is seen high. It is also removed one cycle after its request is withdrawn before busy appears.
- R8: During and after synchronous reset `bus_grant` = 0 and `bus_clr` = 0, the mode is round robin, and the first round-robin search starts at level 3.
- R9: While `sys_en` = 0 no grant is issued. One cycle after `sys_en` is seen low, `bus_grant` = 0 and `bus_clr` = 0.
- R10: A change of `fixed_sel` takes effect only while no grant is outstanding and no owner holds the bus. A switch to fixed priority during an ownership raises no `bus_clr` for that ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_en | input | 1 | High when the board is the system controller |
| fixed_sel | input | 1 | 1 = fixed priority, 0 = round robin |
| bus_req | input | N_LVL | Request levels, active high, bit i = level i |
| bus_busy | input | 1 | Bus busy, active high |
| bus_grant | output | N_LVL | Grant-out per level, active high |
| bus_clr | output | 1 | Bus clear request to the current owner |

## Verification
A grant is due one clock edge after a request is applied with the bus idle. Its removal is due one edge after busy or the withdrawal is applied. A change of bus clear is due one edge after the higher request or the busy release is applied. The bench drives every input on the falling edge and samples on the next falling edge, exactly one register stage later. It never samples during the cycle in which an input changes. The round-robin expectation comes from a small search in the bench over the scan start it keeps itself. Full sweeps of all request patterns in both modes cover each ordering.

// File: rtl/arb_pkg.sv
// Package: shared types for the bus system arbiter.
// Assumes: nothing beyond standard SystemVerilog.
package arb_pkg;

    // Controller phases: idle, grant offered, bus held by the owner
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HELD  = 2'd2
    } arb_state_e;

endpackage

// File: rtl/arb_pick.sv
// Module: arb_pick
// Finds the winning level for both policies from the current requests.
// Fixed policy: highest set bit. Rotating policy: first set bit met when
// walking downward from rr_start, wrapping below 0 to the top level.
// Assumes: purely combinational; the result is meaningful only when any_req.
module arb_pick #(
    parameter int N_LVL = 4,
    localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
    input  logic [N_LVL-1:0] req,
    input  logic [LVL_W-1:0] rr_start,
    output logic             any_req,
    output logic [LVL_W-1:0] fix_lvl,
    output logic [LVL_W-1:0] rr_lvl
);

    // any pending request
    assign any_req = |req;

    // highest set request bit
    always_comb begin
        fix_lvl = '0;
        for (int i = 0; i < N_LVL; i++) begin
            if (req[i]) fix_lvl = LVL_W'(i);
        end
    end

    // first requesting level in a downward wrapped walk from rr_start
    always_comb begin
        logic found;
        found  = 1'b0;
        rr_lvl = '0;
        for (int i = 0; i < N_LVL; i++) begin
            int k;
            k = (int'(rr_start) + N_LVL - i) % N_LVL;
            if (!found && req[k]) begin
                rr_lvl = LVL_W'(k);
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/arb_preempt.sv
// Module: arb_preempt
// Flags any request on a level strictly above the current owner's level.
// Assumes: owner_lvl is valid whenever the result is used.
module arb_preempt #(
    parameter int N_LVL = 4,
    localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
    input  logic [N_LVL-1:0] req,
    input  logic [LVL_W-1:0] owner_lvl,
    output logic             hi_req
);

    logic [N_LVL-1:0] above;

    // one comparator per level
    for (genvar g = 0; g < N_LVL; g++) begin : g_above
        assign above[g] = req[g] && (LVL_W'(g) > owner_lvl);
    end

    // any level above the owner requesting
    assign hi_req = |above;

endmodule

// File: rtl/arb_ctrl.sv
// Module: arb_ctrl
// Sequencer of the arbiter: offers a grant when the bus is idle, withdraws
// it on busy or on request withdrawal, tracks the owner, raises bus clear
// in fixed mode and advances the rotating scan start.
// Assumes: the winner inputs are derived from the same req vector.
module arb_ctrl
    import arb_pkg::*;
#(
    parameter int N_LVL = 4,
    localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_en,
    input  logic             fixed_sel,
    input  logic             busy,
    input  logic [N_LVL-1:0] req,
    input  logic             any_req,
    input  logic [LVL_W-1:0] fix_lvl,
    input  logic [LVL_W-1:0] rr_lvl,
    input  logic             hi_req,
    output logic [N_LVL-1:0] grant,
    output logic             bus_clr,
    output logic [LVL_W-1:0] rr_start,
    output logic [LVL_W-1:0] owner_lvl,
    output logic             mode_fix
);

    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(N_LVL - 1);
    localparam logic [N_LVL-1:0] ONE_HOT0 = N_LVL'(1);

    arb_state_e       st;
    logic             mode_q;
    logic             mode_eff;
    logic [LVL_W-1:0] win_lvl;
    logic [LVL_W-1:0] next_start;

    // mode follows the input only while idle, otherwise the latched value
    assign mode_eff = (st == ST_IDLE) ? fixed_sel : mode_q;

    // winner under the effective policy
    assign win_lvl = mode_eff ? fix_lvl : rr_lvl;

    // scan start after granting win_lvl: one below, wrapping to the top
    assign next_start = (win_lvl == '0) ? TOP_LVL : win_lvl - 1'b1;

    assign mode_fix = mode_q;

    // arbitration sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            grant     <= '0;
            bus_clr   <= 1'b0;
            mode_q    <= 1'b0;
            rr_start  <= TOP_LVL;
            owner_lvl <= '0;
        end else if (!sys_en) begin
            st      <= ST_IDLE;
            grant   <= '0;
            bus_clr <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    mode_q  <= fixed_sel;
                    bus_clr <= 1'b0;
                    if (!busy && any_req) begin
                        grant     <= ONE_HOT0 << win_lvl;
                        owner_lvl <= win_lvl;
                        st        <= ST_OFFER;
                        if (!fixed_sel) rr_start <= next_start;
                    end
                end
                ST_OFFER: begin
                    if (busy) begin
                        grant <= '0;
                        st    <= ST_HELD;
                    end else if (!req[owner_lvl]) begin
                        grant <= '0;
                        st    <= ST_IDLE;
                    end
                end
                ST_HELD: begin
                    if (!busy) begin
                        bus_clr <= 1'b0;
                        st      <= ST_IDLE;
                    end else if (mode_q && hi_req) begin
                        bus_clr <= 1'b1;
                    end
                end
                default: begin
                    st    <= ST_IDLE;
                    grant <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/vme_sys_arbiter.sv
// Module: vme_sys_arbiter
// Top of the system arbiter: request picker, pre-emption detector and
// sequencer wired together.
// Assumes: requests, busy and mode select are synchronous to clk.
module vme_sys_arbiter #(
    parameter int N_LVL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_en,
    input  logic             fixed_sel,
    input  logic [N_LVL-1:0] bus_req,
    input  logic             bus_busy,
    output logic [N_LVL-1:0] bus_grant,
    output logic             bus_clr
);

    localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1;

    logic             any_req;
    logic [LVL_W-1:0] fix_lvl;
    logic [LVL_W-1:0] rr_lvl;
    logic [LVL_W-1:0] rr_start;
    logic [LVL_W-1:0] owner_lvl;
    logic             hi_req;
    logic             mode_fix_w;

    arb_pick #(.N_LVL(N_LVL)) u_pick (
        .req      (bus_req),
        .rr_start (rr_start),
        .any_req  (any_req),
        .fix_lvl  (fix_lvl),
        .rr_lvl   (rr_lvl)
    );

    arb_preempt #(.N_LVL(N_LVL)) u_pre (
        .req       (bus_req),
        .owner_lvl (owner_lvl),
        .hi_req    (hi_req)
    );

    arb_ctrl #(.N_LVL(N_LVL)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_en    (sys_en),
        .fixed_sel (fixed_sel),
        .busy      (bus_busy),
        .req       (bus_req),
        .any_req   (any_req),
        .fix_lvl   (fix_lvl),
        .rr_lvl    (rr_lvl),
        .hi_req    (hi_req),
        .grant     (bus_grant),
        .bus_clr   (bus_clr),
        .rr_start  (rr_start),
        .owner_lvl (owner_lvl),
        .mode_fix  (mode_fix_w)
    );

endmodule

// File: rtl/arb_chk.sv
// Module: arb_chk
// Property checker for vme_sys_arbiter, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module arb_chk #(
    parameter int N_LVL = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_en,
    input logic             bus_busy,
    input logic [N_LVL-1:0] bus_grant,
    input logic             bus_clr,
    input logic             mode_fix
);

    AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_grant)); // R1

    AST_RR_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_fix |-> !bus_clr); // R5

    AST_GRANT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant != '0 && $past(bus_grant) == '0) |-> !$past(bus_busy)); // R6

    AST_GRANT_DROP_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant != '0 && bus_busy) |=> bus_grant == '0); // R7

    AST_CLEAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_clr && bus_busy && sys_en) |=> bus_clr); // R3

    AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_clr && !bus_busy) |=> !bus_clr); // R3

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en |=> (bus_grant == '0 && !bus_clr)); // R9

endmodule

bind vme_sys_arbiter arb_chk #(.N_LVL(N_LVL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_en    (sys_en),
    .bus_busy  (bus_busy),
    .bus_grant (bus_grant),
    .bus_clr   (bus_clr),
    .mode_fix  (mode_fix_w)
);

// File: tb/tb_vme_sys_arbiter.sv
`timescale 1ns/1ps
module tb_vme_sys_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_en = 1'b1;
    logic       fixed_sel = 1'b0;
    logic [3:0] bus_req = '0;
    logic       bus_busy = 1'b0;
    logic [3:0] bus_grant;
    logic       bus_clr;

    int checks = 0;
    int failures = 0;
    int rr_ptr = 3;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vme_sys_arbiter #(.N_LVL(4)) dut (
        .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .fixed_sel(fixed_sel),
        .bus_req(bus_req), .bus_busy(bus_busy),
        .bus_grant(bus_grant), .bus_clr(bus_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] fix_exp(input logic [3:0] r);
        logic [3:0] e = '0;
        for (int i = 0; i < 4; i++) if (r[i]) e = 4'(1 << i);
        return e;
    endfunction

    // rotating expectation: downward wrapped walk from rr_ptr; updates rr_ptr
    function automatic logic [3:0] rr_exp(input logic [3:0] r);
        for (int i = 0; i < 4; i++) begin
            int k = (rr_ptr + 4 - i) % 4;
            if (r[k]) begin
                rr_ptr = (k == 0) ? 3 : k - 1;
                return 4'(1 << k);
            end
        end
        return 4'b0;
    endfunction

    // apply a request with bus idle, check the grant, then complete ownership
    task automatic offer(input logic [3:0] r, input logic [3:0] exp, input string tag);
        bus_req = r; bus_busy = 1'b0;
        @(negedge clk);
        chk(tag, 32'(bus_grant), 32'(exp));
        if (exp != 0) begin
            bus_busy = 1'b1; bus_req = '0;
            @(negedge clk);
            chk("R7 grant drop on busy", 32'(bus_grant), 0);
            bus_busy = 1'b0;
            @(negedge clk);
        end else begin
            bus_req = '0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset grant", 32'(bus_grant), 0);
        chk("R8 reset clear", 32'(bus_clr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: first rotating search starts at level 3
        offer(4'b1111, rr_exp(4'b1111), "R8 first scan start");

        // R4: rotating sweep over many patterns
        for (int n = 0; n < 48; n++) begin
            logic [3:0] r = 4'((n * 7 + 3) % 16);
            offer(r, rr_exp(r), "R4 rotating order");
        end

        // R5: rotating mode never clears, even with higher requests
        offer(4'b0001, rr_exp(4'b0001), "R5 setup");
        bus_req = 4'b0001; bus_busy = 1'b0;
        @(negedge clk);
        bus_busy = 1'b1; bus_req = 4'b1110;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R5 no clear in rotating", 32'(bus_clr), 0);
        end
        bus_busy = 1'b0; bus_req = '0;
        @(negedge clk);

        // R10: mode change during ownership is deferred
        offer(4'b0100, rr_exp(4'b0100), "R10 setup");
        bus_req = 4'b0100;
        @(negedge clk);
        chk("R10 grant level 2", 32'(bus_grant), 32'h4);
        void'(rr_exp(4'b0100));
        bus_busy = 1'b1; bus_req = '0;
        @(negedge clk);
        fixed_sel = 1'b1; bus_req = 4'b1000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 no clear after late mode switch", 32'(bus_clr), 0);
        end
        bus_busy = 1'b0; bus_req = '0;
        @(negedge clk);
        offer(4'b1010, 4'b1000, "R10 fixed taken when idle");

        // R2: fixed sweep over all patterns, twice
        for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < 16; r++) offer(4'(r), fix_exp(4'(r)), "R2 fixed priority");
        end

        // R3: pre-emption by a higher level only
        bus_req = 4'b0010;
        @(negedge clk);
        chk("R3 setup grant", 32'(bus_grant), 32'h2);
        bus_busy = 1'b1; bus_req = '0;
        @(negedge clk);
        bus_req = 4'b0001;
        @(negedge clk);
        chk("R3 lower no clear", 32'(bus_clr), 0);
        bus_req = 4'b0101;
        @(negedge clk);
        chk("R3 clear raised", 32'(bus_clr), 1);
        @(negedge clk);
        chk("R3 clear held", 32'(bus_clr), 1);
        bus_req = 4'b0000;
        @(negedge clk);
        chk("R3 clear held after withdrawal", 32'(bus_clr), 1);
        bus_busy = 1'b0; bus_req = 4'b0101;
        @(negedge clk);
        chk("R3 clear drops on release", 32'(bus_clr), 0);
        @(negedge clk);
        chk("R3 higher level granted", 32'(bus_grant), 32'h4);
        bus_busy = 1'b1; bus_req = '0;
        @(negedge clk);
        bus_busy = 1'b0;
        @(negedge clk);

        // R6: no grant while busy stays high
        bus_busy = 1'b1; bus_req = 4'b0100;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 no grant while busy", 32'(bus_grant), 0);
        end
        bus_busy = 1'b0;
        @(negedge clk);
        chk("R6 grant after idle", 32'(bus_grant), 32'h4);
        bus_busy = 1'b1; bus_req = '0;
        @(negedge clk);
        bus_busy = 1'b0;
        @(negedge clk);

        // R7: withdrawal before busy removes the grant
        bus_req = 4'b0010;
        @(negedge clk);
        chk("R7 withdraw setup", 32'(bus_grant), 32'h2);
        bus_req = '0;
        @(negedge clk);
        chk("R7 grant drop on withdrawal", 32'(bus_grant), 0);

        // R9: disabled arbiter stays quiet
        sys_en = 1'b0; bus_req = 4'b1111;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 no grant when disabled", 32'(bus_grant), 0);
        end
        sys_en = 1'b1;
        @(negedge clk);
        chk("R9 grant after enable", 32'(bus_grant), 32'h8);
        sys_en = 1'b0;
        @(negedge clk);
        chk("R9 grant cleared on disable", 32'(bus_grant), 0);
        chk("R9 clear quiet on disable", 32'(bus_clr), 0);
        sys_en = 1'b1; bus_req = '0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule